// File: doc/BRIEF.md
# Voice Interrupt Pending Stack

This block gathers interrupt events raised by up to 32 synthesis voices and hands them back to a host one at a time. A voice engine posts an event as a push, with a 5-bit voice number plus a wave flag (the sample reached its end) and a ramp flag (the volume ramp reached its end). When the host reads the interrupt-source register, one event is removed and returned as an encoded status byte.

The events sit on a stack, so the host always sees the most recent event first. The global wave-pending and ramp-pending status bits always show the flags of the entry now at the top. The status byte marks each flag by its absence: a bit is set when the event does not carry that flag. An interrupt line to the system stays asserted while events are waiting and interrupts are enabled. The line drops during any cycle in which the host reads the source register. A clear input or reset discards every stored event.

Top module: `vip_stack`

## Requirements
- R1: Events leave in last-in-first-out order. During a cycle with `pop_req` high, `rd_byte` shows the entry that this pop removes, and the entry is gone after the clock edge.
- R2: `rd_byte` encoding: bit 7 = 1 when the entry has no wave flag, bit 6 = 1 when it has no ramp flag, bit 5 = 1 always, bits 4..0 = voice number.
- R3: A push that reaches the store while it holds DEPTH entries is dropped, and the stored entries keep their values and their order.
- R4: `wave_pend` and `ramp_pend` show the flags of the top entry. They take a pushed entry's flags in the cycle after the push edge, and after a pop they take the flags of the entry below.
- R5: When the stack is empty, `wave_pend` and `ramp_pend` are 0. A pop from an empty stack returns `rd_byte` = 8'hE0 (voice 0, neither flag) and leaves the stack empty.
- R6: `irq_out` is high when the stack is not empty and `irq_en` is high, and low in every cycle in which `pop_req` is high.
- R7: When a push and a pop arrive in the same cycle, the pop is carried out first and the push is stored on the next clock edge.
- R8: While a deferred push waits, a cycle with a pop keeps it waiting and drops any new push in that cycle. A cycle without a pop stores the waiting entry, and a new push in that cycle becomes the waiting entry.
- R9: `clr_all` or reset empties the stack and discards a waiting push within one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_all | input | 1 | Synchronous clear of all stored events |
| irq_en | input | 1 | Global interrupt enable |
| push_valid | input | 1 | Push request from a voice |
| push_voice | input | 5 | Voice number of the pushed event |
| push_wave | input | 1 | End-of-sample flag of the pushed event |
| push_ramp | input | 1 | End-of-ramp flag of the pushed event |
| pop_req | input | 1 | Host read of the interrupt-source register |
| rd_byte | output | 8 | Encoded status byte of the top entry |
| wave_pend | output | 1 | Wave flag of the top entry |
| ramp_pend | output | 1 | Ramp flag of the top entry |
| irq_out | output | 1 | Interrupt request line |

## Verification
The bench fills the stack and then keeps pushing. A design with a wrong full test would wrap its pointer and return stale or shuffled entries when the stack drains. It pops an empty stack, where a pointer that underflows would show junk instead of 8'hE0 or would leave false pending flags. It pairs pushes with pops, also while a deferred push is already waiting. A wrong priority there shows up as the wrong entry being removed, or as a deferred event that is lost or stored twice. A clear that arrives with a push waiting must not let that push come back one cycle later.

// File: rtl/vip_pkg.sv
package vip_pkg;
   localparam int VOICE_W = 5;

   typedef struct packed {
      logic              ramp;
      logic              wave;
      logic [VOICE_W-1:0] voice;
   } vip_ent_t;
endpackage

// File: rtl/vip_defer.sv
module vip_defer
   import vip_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     pop,
   input  logic     in_valid,
   input  vip_ent_t in_ent,
   output logic     go,
   output vip_ent_t go_ent
);
   logic     slot_v;
   vip_ent_t slot;
   logic     src_v;
   vip_ent_t src;

   assign src_v  = slot_v | in_valid;
   assign src    = slot_v ? slot : in_ent;
   assign go     = src_v & ~pop & ~clr;
   assign go_ent = src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_v <= 1'b0;
         slot   <= '0;
      end else if (clr) begin
         slot_v <= 1'b0;
      end else if (pop) begin
         slot_v <= src_v;
         slot   <= src;
      end else begin
         slot_v <= slot_v & in_valid;
         slot   <= in_ent;
      end
   end

   AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && in_valid && !clr) |=> slot_v) else $error("defer lost"); // R7
   AST_DEFER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_v && !pop && !in_valid && !clr) |=> !slot_v) else $error("defer stuck"); // R8
endmodule

// File: rtl/vip_store.sv
module vip_store
   import vip_pkg::*;
#(
   parameter int DEPTH = 1024
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     pop,
   input  logic     push,
   input  vip_ent_t push_ent,
   output vip_ent_t top,
   output logic     empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("vip_store: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   vip_ent_t        mem [DEPTH];
   logic [PW-1:0]   ptr;
   logic [PW-1:0]   ptr_up;
   logic            full;
   logic            do_push;

   assign empty   = &ptr;
   assign full    = (ptr == LAST);
   assign ptr_up  = ptr + 1'b1;
   assign do_push = push & ~full & ~pop & ~clr;
   assign top     = mem[ptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               ptr <= '1;
      else if (clr)             ptr <= '1;
      else if (pop && !empty)   ptr <= ptr - 1'b1;
      else if (do_push)         ptr <= ptr_up;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[ptr_up[AW-1:0]] <= push_ent;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (empty || ptr <= LAST)) else $error("pointer overflow"); // R3
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> $stable(ptr)) else $error("full push moved"); // R3
   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !clr) |=> (ptr == $past(ptr) - 1'b1)) else $error("pop step"); // R1
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !clr) |=> empty) else $error("empty pop"); // R5
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty) else $error("clear"); // R9
endmodule

// File: rtl/vip_encode.sv
module vip_encode
   import vip_pkg::*;
(
   input  vip_ent_t   ent,
   input  logic       empty,
   output logic [7:0] code
);
   localparam int PAD = 5 - VOICE_W;
   logic [4:0] vnum;

   generate
      if (VOICE_W > 5) begin : g_bad_voice
         $error("vip_encode: voice number wider than the status field");
      end else if (PAD > 0) begin : g_pad
         assign vnum = empty ? 5'd0 : {{PAD{1'b0}}, ent.voice};
      end else begin : g_full
         assign vnum = empty ? 5'd0 : ent.voice;
      end
   endgenerate

   assign code = {~(ent.wave & ~empty), ~(ent.ramp & ~empty), 1'b1, vnum};

   always_comb begin
      AST_CODE_FIXED_BIT: assert (code[5]) else $error("bit5 clear"); // R2
   end
endmodule

// File: rtl/vip_stack.sv
module vip_stack
   import vip_pkg::*;
#(
   parameter int DEPTH = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_all,
   input  logic       irq_en,
   input  logic       push_valid,
   input  logic [4:0] push_voice,
   input  logic       push_wave,
   input  logic       push_ramp,
   input  logic       pop_req,
   output logic [7:0] rd_byte,
   output logic       wave_pend,
   output logic       ramp_pend,
   output logic       irq_out
);
   vip_ent_t in_ent;
   vip_ent_t go_ent;
   vip_ent_t top;
   logic     go;
   logic     empty;

   assign in_ent.voice = push_voice[VOICE_W-1:0];
   assign in_ent.wave  = push_wave;
   assign in_ent.ramp  = push_ramp;

   vip_defer u_defer (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .pop(pop_req),
      .in_valid(push_valid), .in_ent(in_ent), .go(go), .go_ent(go_ent)
   );

   vip_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .pop(pop_req),
      .push(go), .push_ent(go_ent), .top(top), .empty(empty)
   );

   vip_encode u_enc (.ent(top), .empty(empty), .code(rd_byte));

   assign wave_pend = ~empty & top.wave;
   assign ramp_pend = ~empty & top.ramp;
   assign irq_out   = ~empty & irq_en & ~pop_req;

   AST_EMPTY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_byte[4:0] == 5'd0 && rd_byte[7] && rd_byte[6]) || irq_out || !irq_en || pop_req
      || wave_pend || ramp_pend || rd_byte[4:0] != 5'd0) else $error("flags"); // R4
   AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !clr_all && empty) |=> (wave_pend == $past(go_ent.wave))) else $error("push flags"); // R4
endmodule

// File: tb/vip_stack_test.sv
module vip_stack_test;
   localparam int DEPTH = 8;

   logic clk = 0;
   logic rst_n = 0;
   logic clr_all = 0, irq_en = 0, push_valid = 0, push_wave = 0, push_ramp = 0, pop_req = 0;
   logic [4:0] push_voice = 0;
   logic [7:0] rd_byte;
   logic wave_pend, ramp_pend, irq_out;

   always #10 clk = ~clk;

   vip_stack #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .irq_en(irq_en),
      .push_valid(push_valid), .push_voice(push_voice), .push_wave(push_wave),
      .push_ramp(push_ramp), .pop_req(pop_req), .rd_byte(rd_byte),
      .wave_pend(wave_pend), .ramp_pend(ramp_pend), .irq_out(irq_out)
   );

   int n_cmp = 0, n_bad = 0;
   logic [6:0] stk[$];
   logic slot_v = 0;
   logic [6:0] slot = 0;
   string tag = "R9";

   task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", t, act, exp);
      end
   endtask

   function automatic logic [7:0] enc(logic [6:0] e);
      return {~e[5], ~e[6], 1'b1, e[4:0]};
   endfunction

   task automatic compare();
      logic [6:0] t;
      logic ne;
      ne = stk.size() > 0;
      t = ne ? stk[$] : 7'd0;
      chk({tag, " rd_byte"}, rd_byte, ne ? enc(t) : 8'hE0);
      chk({tag, " flags"}, {6'd0, wave_pend, ramp_pend}, {6'd0, t[5] & ne, t[6] & ne});
      chk({tag, " R6 irq"}, {7'd0, irq_out}, {7'd0, ne & irq_en & ~pop_req});
   endtask

   task automatic model();
      logic sv;
      logic [6:0] s, inp;
      inp = {push_ramp, push_wave, push_voice};
      sv = slot_v | push_valid;
      s = slot_v ? slot : inp;
      if (clr_all) begin
         stk.delete(); slot_v = 0;
      end else if (pop_req) begin
         if (stk.size() > 0) void'(stk.pop_back());
         slot_v = sv; slot = s;
      end else begin
         if (sv && stk.size() < DEPTH) stk.push_back(s);
         slot_v = slot_v & push_valid; slot = inp;
      end
   endtask

   task automatic cyc(bit pu, logic [4:0] v, bit w, bit r, bit po, bit cl = 0);
      @(negedge clk);
      push_valid = pu; push_voice = v; push_wave = w; push_ramp = r;
      pop_req = po; clr_all = cl;
      #2 compare();
      @(posedge clk);
      #1 model();
   endtask

   bit done = 0;
   initial begin
      #(200000 * 20);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tag = "R9"; cyc(0, 0, 0, 0, 0);
      irq_en = 1;
      tag = "R4"; cyc(1, 5'd3, 1, 1, 0); cyc(1, 5'd17, 0, 1, 0); cyc(1, 5'd5, 1, 0, 0);
      cyc(0, 0, 0, 0, 0);
      @(negedge clk); #2 chk("R2 encode", rd_byte, 8'h65);
      tag = "R1"; cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1);
      tag = "R5";
      @(negedge clk); pop_req = 1; #2 chk("R5 empty pop", rd_byte, 8'hE0);
      @(posedge clk); #1 model();
      cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
      tag = "R3";
      for (int i = 0; i < DEPTH + 3; i++) cyc(1, 5'(i + 8), i[0], i[1], 0);
      tag = "R1";
      for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, 0, 1);
      tag = "R7"; cyc(1, 5'd9, 1, 0, 0); cyc(1, 5'd21, 0, 1, 1); cyc(0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      @(negedge clk); #2 chk("R7 deferred top", rd_byte, 8'hB5);
      tag = "R8"; cyc(1, 5'd1, 1, 1, 1); cyc(1, 5'd2, 0, 0, 1); cyc(1, 5'd4, 1, 0, 0);
      cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
      tag = "R6"; irq_en = 0; cyc(0, 0, 0, 0, 0); irq_en = 1; cyc(0, 0, 0, 0, 0);
      tag = "R9"; cyc(1, 5'd7, 1, 1, 1); cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      tag = "R1";
      for (int i = 0; i < 400; i++)
         cyc($urandom_range(0, 2) != 0, 5'($urandom), 1'($urandom), 1'($urandom),
             $urandom_range(0, 3) == 0, $urandom_range(0, 60) == 0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule